// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block guards a running system against software that has stopped making progress. While enabled it counts clock cycles against a timeout picked by a 3-bit select. Software keeps it quiet by writing a two-byte key pair to a single arm register through a write strobe and an 8-bit data bus. The first key is 0x55 and the second is 0xAA. A completed pair starts the timeout over.

If the timeout runs out before a pair completes, the block raises a one-cycle reset request. It does the same as soon as a byte arrives that is not the key it expects next. The request is meant to feed the chip's reset generator. That generator then applies the synchronous reset, which returns the watchdog to its initial state.

Top module: `keyseq_wdog`

## Requirements
- R1: After the synchronous reset `rst_i`, `rst_req_o` is low. A period then starts from count zero once `wdog_en_i` is high.
- R2: While `wdog_en_i` is low, the block never requests a reset and ignores every arm write. A 0x55 written while disabled leaves no armed state behind, and the count is held at zero.
- R3: The period is 2^(BASE_EXP+k) cycles, where k is 0,1,2,3,4,6,8,10 for `period_sel_i` = 0..7, and BASE_EXP is 14 by default. With no service, `rst_req_o` first reads high on the 2^(BASE_EXP+k)-th rising edge after enable.
- R4: Writing 0x55 and then 0xAA restarts the period. The next expiry then comes a full period after the edge that took 0xAA, and no request follows the pair itself.
- R5: When no key has been accepted yet, a write of any byte other than 0x55 raises `rst_req_o` on the edge that takes the write.
- R6: Once 0x55 has been accepted, any byte other than 0xAA, including a second 0x55, raises `rst_req_o` on the edge that takes the write.
- R7: Each request is high for exactly one cycle. The event that caused it also clears the key state and restarts the count from zero.
- R8: A pair whose 0xAA lands on the last cycle of the period still counts as on time. A lone 0x55 in that cycle does not prevent expiry.
- R9: Asserting `rst_i` during operation clears the request, the count and any accepted first key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wdog_en_i | input | 1 | Watchdog enable |
| period_sel_i | input | SEL_W (3) | Timeout length select |
| arm_wr_i | input | 1 | One-cycle write strobe for the arm register |
| arm_data_i | input | 8 | Byte written to the arm register |
| rst_req_o | output | 1 | Registered one-cycle reset request |

## Verification
The assertions assume `rst_i` is applied at time zero. They also assume the enable and period select change only between clock edges, and that a write strobe lasts exactly one cycle per byte. The bench drives every input on the falling edge and holds each strobe for one cycle only. It changes the period select only while the watchdog is disabled, so the count never starts above a newly chosen limit. The bench overrides BASE_EXP to 4 so that all eight periods can be measured exactly.

// File: rtl/kswd_pkg.sv
package kswd_pkg;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // exponent step above the base for each select code
  function automatic int unsigned sel_offset(input int unsigned s);
    return (s <= 4) ? s : (2 * s - 4);
  endfunction

endpackage

// File: rtl/kswd_keyseq.sv
module kswd_keyseq
  import kswd_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  FIRST  = KEY_FIRST,
  parameter logic [7:0]  SECOND = KEY_SECOND
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              svc_o,
  output logic              err_o
);

  key_st_e state_q, state_d;

  always_comb begin
    svc_o = 1'b0;
    err_o = 1'b0;
    if (en_i && wr_i) begin
      if (state_q == KEY_IDLE) begin
        err_o = (data_i != DATA_W'(FIRST));
      end else if (data_i == DATA_W'(SECOND)) begin
        svc_o = 1'b1;
      end else begin
        err_o = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if (!en_i || clr_i || err_o || svc_o) begin
      state_d = KEY_IDLE;
    end else if (wr_i && state_q == KEY_IDLE) begin
      state_d = KEY_ARMED;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= KEY_IDLE;
    else       state_q <= state_d;
  end

  // R4: the armed state is only entered from a first-key write
  p_arm_needs_first_key_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(state_q == KEY_ARMED) |-> $past(wr_i && data_i == DATA_W'(FIRST)));

  // R2: disabling drops any half-finished pair
  p_off_drops_key_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> state_q == KEY_IDLE);

endmodule

// File: rtl/kswd_timer.sv
module kswd_timer
  import kswd_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             kick_i,
  output logic             expire_o
);

  localparam int NUM_SEL = 2 ** SEL_W;
  localparam int MAX_OFF = int'(sel_offset(NUM_SEL - 1));
  localparam int CNT_W   = BASE_EXP + MAX_OFF;

  logic [CNT_W-1:0] lim_tab [NUM_SEL];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    localparam int EXP = BASE_EXP + int'(sel_offset(g));
    assign lim_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  assign lim      = lim_tab[sel_i];
  assign expire_o = en_i && (cnt_q >= lim) && !kick_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i || kick_i || expire_o) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // R2: the count rests at zero while disabled
  p_idle_count_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> cnt_q == '0);

  // R3: a count at or past the selected limit restarts on the next edge
  p_limit_restarts_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && cnt_q >= lim) |=> cnt_q == '0);

endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
  import kswd_pkg::*;
#(
  parameter int          BASE_EXP   = 14,
  parameter int          SEL_W      = 3,
  parameter logic [7:0]  FIRST_KEY  = KEY_FIRST,
  parameter logic [7:0]  SECOND_KEY = KEY_SECOND
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wdog_en_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic             arm_wr_i,
  input  logic [7:0]       arm_data_i,
  output logic             rst_req_o
);

  logic svc, key_err, expire, req_q;

  kswd_keyseq #(
    .DATA_W (8),
    .FIRST  (FIRST_KEY),
    .SECOND (SECOND_KEY)
  ) u_keys (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (wdog_en_i),
    .wr_i   (arm_wr_i),
    .data_i (arm_data_i),
    .clr_i  (expire),
    .svc_o  (svc),
    .err_o  (key_err)
  );

  kswd_timer #(
    .BASE_EXP (BASE_EXP),
    .SEL_W    (SEL_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (wdog_en_i),
    .sel_i    (period_sel_i),
    .kick_i   (svc | key_err),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) req_q <= 1'b0;
    else       req_q <= expire | key_err;
  end

  assign rst_req_o = req_q;

  // R5: a byte that is neither key always triggers a request
  p_bad_byte_req_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wdog_en_i && arm_wr_i && arm_data_i != FIRST_KEY && arm_data_i != SECOND_KEY)
      |=> rst_req_o);

  // R2: no request follows a disabled cycle
  p_no_req_when_off_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!wdog_en_i) |-> !rst_req_o);

  // R4: a completed pair is never punished
  p_pair_no_req_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    svc |=> !rst_req_o);

  // R9: reset leaves the request low
  p_reset_clears_req_r9: assert property (@(posedge clk_i)
    rst_i |=> !rst_req_o);

endmodule

// File: tb/keyseq_wdog_tb_top.sv
module keyseq_wdog_tb_top;

  localparam int BEXP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr = 1'b0;
  logic [7:0] data = 8'h00;
  logic       req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  keyseq_wdog #(.BASE_EXP(BEXP)) dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .wdog_en_i    (en),
    .period_sel_i (sel),
    .arm_wr_i     (wr),
    .arm_data_i   (data),
    .rst_req_o    (req)
  );

  function automatic int period_of(input int s);
    int offs [8] = '{0, 1, 2, 3, 4, 6, 8, 10};
    return 1 << (BEXP + offs[s]);
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk);
    wr = 1'b1; data = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // cycles (falling edges) until req reads high; 0 if never within lim
  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (req) begin n = i; return; end
    end
  endtask

  task automatic fresh(input int s);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    sel = 3'(s);
    en = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 req low in reset", int'(req), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req low after reset", int'(req), 0);
  endtask

  task automatic t_periods();
    int n;
    for (int s = 0; s < 8; s++) begin
      fresh(s);
      wait_pulse(period_of(s) + 8, n);
      check($sformatf("R3 period sel %0d", s), n, period_of(s));
      @(negedge clk);
      check("R7 pulse one cycle wide", int'(req), 0);
      if (s == 0) begin
        wait_pulse(period_of(0) + 8, n);
        check("R7 count restarts after expiry", n, period_of(0) - 1);
      end
    end
  endtask

  task automatic t_service();
    int n;
    fresh(0);
    for (int k = 0; k < 5; k++) begin
      repeat (8) @(negedge clk);
      check("R4 no req before pair", int'(req), 0);
      wr_byte(8'h55);
      check("R4 no req after first key", int'(req), 0);
      wr_byte(8'hAA);
      check("R4 no req after second key", int'(req), 0);
    end
    wait_pulse(period_of(0) + 8, n);
    check("R4 full period after pair", n, period_of(0));
  endtask

  task automatic t_bad_first();
    fresh(2);
    wr_byte(8'h00);
    check("R5 wrong first byte", int'(req), 1);
    @(negedge clk);
    check("R7 error pulse one cycle", int'(req), 0);
    wr_byte(8'hAA);
    check("R5 second key first", int'(req), 1);
  endtask

  task automatic t_bad_second();
    fresh(2);
    wr_byte(8'h55);
    check("R6 no req after first", int'(req), 0);
    wr_byte(8'h55);
    check("R6 repeated first key", int'(req), 1);
    wr_byte(8'h55);
    wr_byte(8'h12);
    check("R6 other byte after first", int'(req), 1);
    wr_byte(8'hAA);
    check("R7 key state cleared by error", int'(req), 1);
  endtask

  task automatic t_disabled();
    int n;
    @(negedge clk);
    en = 1'b0;
    wr_byte(8'h13);
    check("R2 bad byte ignored when off", int'(req), 0);
    wr_byte(8'h55);
    wait_pulse(period_of(3) + 4, n);
    check("R2 no expiry when off", n, 0);
    sel = 3'd0;
    en = 1'b1;
    wr_byte(8'hAA);
    check("R2 first key while off not kept", int'(req), 1);
  endtask

  task automatic t_last_cycle();
    int n;
    int p = period_of(0);
    fresh(0);
    repeat (p - 2) @(negedge clk);
    wr = 1'b1; data = 8'h55;
    @(negedge clk);
    data = 8'hAA;
    @(negedge clk);
    wr = 1'b0;
    check("R8 pair on last cycle on time", int'(req), 0);
    wait_pulse(p + 8, n);
    check("R8 period after late pair", n, p);
    fresh(0);
    repeat (p - 1) @(negedge clk);
    wr = 1'b1; data = 8'h55;
    @(negedge clk);
    wr = 1'b0;
    check("R8 lone first key still expires", int'(req), 1);
    wr_byte(8'hAA);
    check("R7 expiry clears key state", int'(req), 1);
  endtask

  task automatic t_sync_reset();
    int n;
    fresh(0);
    repeat (10) @(negedge clk);
    wr_byte(8'h55);
    rst = 1'b1;
    @(negedge clk);
    check("R9 req low in reset", int'(req), 0);
    rst = 1'b0;
    wr_byte(8'hAA);
    check("R9 key state cleared by reset", int'(req), 1);
    wait_pulse(period_of(0) + 8, n);
    check("R9 count restarts", n, period_of(0));
  endtask

  initial begin
    t_reset();
    t_periods();
    t_service();
    t_bad_first();
    t_bad_second();
    t_disabled();
    t_last_cycle();
    t_sync_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule